// File: doc/BRIEF.md
# Transfer Checksum Snooper

This block watches the stream of data words written by a DMA engine and folds the words from one chosen channel into a 32-bit accumulator. The fold is either a CRC32 step or a 32-bit sum. A control register picks the channel, turns the unit on and selects the fold. Each observed word also carries a per-transfer enable, and the word is folded only when that enable is set.

Software reaches both registers over a simple register bus. Two upper address bits choose how a write lands. A plain write replaces the register. The other three codes use the written value as a mask that flips, sets or clears bits in one cycle. A DMA engine can therefore run OR, AND, XOR and NOT on the accumulator using data moves alone. Reading the accumulator can return it bit-reversed, inverted or both. These readout settings never change the stored value.

Top module: `sniff_unit`

## Requirements
- R1: After reset, both the control register and the accumulator read as zero.
- R2: A word on obs_data_i is folded only when all of these hold in the same cycle: obs_valid_i is high, obs_sniff_i is high, control bit 0 (enable) is set, and control bits 4:1 equal obs_chan_i. Otherwise the accumulator keeps its value.
- R3: When control bits 8:5 are 0x0, each folded word updates the accumulator by one CRC32 step. The step uses polynomial 0x04C11DB7, takes data bits from bit 31 down to bit 0, and applies no reflection and no final XOR. One word is processed per cycle, and the result can be read in the following cycle.
- R4: A plain write (address bits 13:12 = 00) to offset 0x008 loads the raw accumulator with the written value. This is how a checksum is seeded.
- R5: When control bits 8:5 are 0xF, each folded word is added to the accumulator modulo 2^32.
- R6: Writes to offset 0x008 with address bits 13:12 = 01 XOR the mask into the accumulator, 10 OR it in, and 11 clear the bits the mask has set. Writing all ones through the XOR code therefore yields the complement.
- R7: Offset 0x004 is the 12-bit control register. The same four write codes apply to it, and its upper 20 read bits are zero.
- R8: On an accumulator read, control bit 10 reverses the bit order and control bit 11 inverts every bit. The two settings combine, and neither changes the stored value.
- R9: Calculation codes other than 0x0 and 0xF leave the accumulator unchanged when a word is observed.
- R10: If a register write to offset 0x008 and an observed word fall in the same cycle, the register write takes effect and the word is dropped.
- R11: reg_rdata_o follows reg_addr_i without a clock. It decodes only address bits 11:0, ignores the write-code bits, and returns zero for any unmapped offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| obs_valid_i | input | 1 | A DMA data word is being written this cycle |
| obs_chan_i | input | 4 | Channel number of that word |
| obs_sniff_i | input | 1 | Per-transfer sniff enable |
| obs_data_i | input | 32 | The data word |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 14 | Bits 13:12 write code, bits 11:0 offset |
| reg_wdata_i | input | 32 | Register write data or mask |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |

## Verification
The hardest case to reach is a register write to the accumulator that arrives in the same cycle as a qualifying observed word, because the two inputs normally come from different masters. The bench drives both in one cycle and expects to read back only the seed. A second hard case is the unknown calculation code. It appears only after the calculation field has been cleared and re-set through the alias writes, and the stimulus reaches it that way before sending a matching word. The readout settings are checked against fixed values whose reversed and inverted forms differ visibly, and the raw value is read again once both settings are cleared.

// File: rtl/sniff_pkg.sv
package sniff_pkg;
  typedef enum logic [1:0] {
    OP_PLAIN = 2'b00,
    OP_XOR   = 2'b01,
    OP_SET   = 2'b10,
    OP_CLR   = 2'b11
  } alias_op_e;

  localparam int unsigned CTRL_W   = 12;
  localparam int unsigned SEL_W    = 4;
  localparam logic [3:0]  CALC_CRC = 4'h0;
  localparam logic [3:0]  CALC_ADD = 4'hF;
  localparam logic [11:0] CTRL_OFF = 12'h004;
  localparam logic [11:0] ACC_OFF  = 12'h008;

  localparam int unsigned B_EN   = 0;
  localparam int unsigned B_REV  = 10;
  localparam int unsigned B_INV  = 11;
endpackage

// File: rtl/sniff_alias.sv
module sniff_alias
  import sniff_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  alias_op_e      op_i,
  input  logic [W-1:0]   old_i,
  input  logic [W-1:0]   wdata_i,
  output logic [W-1:0]   new_o
);
  always_comb begin
    unique case (op_i)
      OP_XOR:  new_o = old_i ^ wdata_i;
      OP_SET:  new_o = old_i | wdata_i;
      OP_CLR:  new_o = old_i & ~wdata_i;
      default: new_o = wdata_i;
    endcase
  end
endmodule

// File: rtl/sniff_fold.sv
module sniff_fold
  import sniff_pkg::*;
#(
  parameter int unsigned W    = 32,
  parameter logic [W-1:0] POLY = 32'h04C11DB7
) (
  input  logic [3:0]   calc_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] next_o,
  output logic         known_o
);
  logic [W-1:0] crc_next;

  // full word per cycle, MSB first
  always_comb begin
    logic [W-1:0] c;
    logic fb;
    c = acc_i;
    for (int i = W - 1; i >= 0; i--) begin
      fb = c[W-1] ^ data_i[i];
      c  = {c[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    crc_next = c;
  end

  always_comb begin
    known_o = 1'b1;
    unique case (calc_i)
      CALC_CRC: next_o = crc_next;
      CALC_ADD: next_o = acc_i + data_i;
      default: begin
        next_o  = acc_i;
        known_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/sniff_out.sv
module sniff_out #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] acc_i,
  input  logic         rev_i,
  input  logic         inv_i,
  output logic [W-1:0] res_o
);
  logic [W-1:0] rev_w;

  for (genvar g = 0; g < W; g++) begin : g_rev
    assign rev_w[g] = acc_i[W-1-g];
  end

  logic [W-1:0] pick_w;
  assign pick_w = rev_i ? rev_w : acc_i;
  assign res_o  = inv_i ? ~pick_w : pick_w;
endmodule

// File: rtl/sniff_unit.sv
module sniff_unit
  import sniff_pkg::*;
#(
  parameter int unsigned  DATA_W = 32,
  parameter int unsigned  CHAN_W = 4,
  parameter int unsigned  ADDR_W = 14,
  parameter logic [DATA_W-1:0] POLY = 32'h04C11DB7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              obs_valid_i,
  input  logic [CHAN_W-1:0] obs_chan_i,
  input  logic              obs_sniff_i,
  input  logic [DATA_W-1:0] obs_data_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);
  localparam int unsigned OFF_W = ADDR_W - 2;

  logic [CTRL_W-1:0] ctrl_q, ctrl_new;
  logic [DATA_W-1:0] acc_q, acc_new, fold_next, acc_view;
  logic              fold_known;

  alias_op_e  op;
  logic [OFF_W-1:0] off;
  assign op  = alias_op_e'(reg_addr_i[ADDR_W-1 -: 2]);
  assign off = reg_addr_i[OFF_W-1:0];

  logic wr_ctrl, wr_acc, hit;
  assign wr_ctrl = reg_we_i && (off == OFF_W'(CTRL_OFF));
  assign wr_acc  = reg_we_i && (off == OFF_W'(ACC_OFF));
  assign hit     = obs_valid_i && obs_sniff_i && ctrl_q[B_EN]
                   && (ctrl_q[SEL_W:1] == SEL_W'(obs_chan_i));

  sniff_alias #(.W(CTRL_W)) i_ctrl_alias (
    .op_i    (op),
    .old_i   (ctrl_q),
    .wdata_i (reg_wdata_i[CTRL_W-1:0]),
    .new_o   (ctrl_new)
  );

  sniff_alias #(.W(DATA_W)) i_acc_alias (
    .op_i    (op),
    .old_i   (acc_q),
    .wdata_i (reg_wdata_i),
    .new_o   (acc_new)
  );

  sniff_fold #(.W(DATA_W), .POLY(POLY)) i_fold (
    .calc_i  (ctrl_q[8:5]),
    .acc_i   (acc_q),
    .data_i  (obs_data_i),
    .next_o  (fold_next),
    .known_o (fold_known)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      acc_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_new;
      // register write wins over an observed word
      if (wr_acc)                  acc_q <= acc_new;
      else if (hit && fold_known)  acc_q <= fold_next;
    end
  end

  sniff_out #(.W(DATA_W)) i_out (
    .acc_i (acc_q),
    .rev_i (ctrl_q[B_REV]),
    .inv_i (ctrl_q[B_INV]),
    .res_o (acc_view)
  );

  always_comb begin
    if (off == OFF_W'(CTRL_OFF))     reg_rdata_o = DATA_W'(ctrl_q);
    else if (off == OFF_W'(ACC_OFF)) reg_rdata_o = acc_view;
    else                             reg_rdata_o = '0;
  end
endmodule

// File: rtl/sniff_unit_chk.sv
module sniff_unit_chk
  import sniff_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CHAN_W = 4,
  parameter int unsigned ADDR_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              obs_valid_i,
  input logic [CHAN_W-1:0] obs_chan_i,
  input logic              obs_sniff_i,
  input logic [DATA_W-1:0] obs_data_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] acc_q
);
  localparam int unsigned OFF_W = ADDR_W - 2;

  logic acc_wr, sel_ok;
  assign acc_wr = reg_we_i && (reg_addr_i[OFF_W-1:0] == OFF_W'(ACC_OFF));
  assign sel_ok = obs_valid_i && obs_sniff_i && ctrl_q[0]
                  && (ctrl_q[4:1] == 4'(obs_chan_i));

  p_filter_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_ok && !acc_wr) |=> $stable(acc_q));

  p_add_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_ok && !acc_wr && ctrl_q[8:5] == 4'hF)
      |=> acc_q == $past(acc_q) + $past(obs_data_i));

  p_set_alias_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr && reg_addr_i[ADDR_W-1 -: 2] == 2'b10)
      |=> acc_q == ($past(acc_q) | $past(reg_wdata_i)));

  p_invert_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i[OFF_W-1:0] == OFF_W'(ACC_OFF) && ctrl_q[11] && !ctrl_q[10])
      |-> reg_rdata_o == ~acc_q);

  p_unknown_calc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_ok && !acc_wr && ctrl_q[8:5] != 4'h0 && ctrl_q[8:5] != 4'hF)
      |=> $stable(acc_q));

  p_write_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr && reg_addr_i[ADDR_W-1 -: 2] == 2'b00)
      |=> acc_q == $past(reg_wdata_i));
endmodule

bind sniff_unit sniff_unit_chk #(
  .DATA_W(DATA_W), .CHAN_W(CHAN_W), .ADDR_W(ADDR_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .obs_valid_i (obs_valid_i),
  .obs_chan_i  (obs_chan_i),
  .obs_sniff_i (obs_sniff_i),
  .obs_data_i  (obs_data_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .ctrl_q      (ctrl_q),
  .acc_q       (acc_q)
);

// File: tb/test_sniff_unit.sv
module test_sniff_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        obs_valid_i = 1'b0;
  logic [3:0]  obs_chan_i = '0;
  logic        obs_sniff_i = 1'b0;
  logic [31:0] obs_data_i = '0;
  logic        reg_we_i = 1'b0;
  logic [13:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;

  sniff_unit i_sniff_unit (.*);

  always #10 clk_i = ~clk_i;

  localparam logic [11:0] O_CTRL = 12'h004;
  localparam logic [11:0] O_ACC  = 12'h008;

  int vectors = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [11:0] m_ctrl = '0;
  logic [31:0] m_acc  = '0;

  function automatic logic [31:0] ref_crc(logic [31:0] c, logic [31:0] d);
    for (int k = 0; k < 32; k++) begin
      if (c[31] ^ d[31-k]) c = (c << 1) ^ 32'h04C11DB7;
      else                 c = c << 1;
    end
    return c;
  endfunction

  function automatic logic [31:0] masked(logic [1:0] op, logic [31:0] o, logic [31:0] d);
    case (op)
      2'b01:   return o ^ d;
      2'b10:   return o | d;
      2'b11:   return o & ~d;
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] view();
    logic [31:0] v;
    v = m_acc;
    if (m_ctrl[10]) for (int k = 0; k < 32; k++) v[k] = m_acc[31-k];
    if (m_ctrl[11]) v = ~v;
    return v;
  endfunction

  task automatic wr(input logic [1:0] op, input logic [11:0] off, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = {op, off}; reg_wdata_i = d;
    if (off == O_CTRL) m_ctrl = 12'(masked(op, 32'(m_ctrl), d));
    if (off == O_ACC)  m_acc  = masked(op, m_acc, d);
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic model_obs(input logic [3:0] ch, input logic s, input logic [31:0] d);
    if (s && m_ctrl[0] && m_ctrl[4:1] == ch) begin
      if (m_ctrl[8:5] == 4'h0)      m_acc = ref_crc(m_acc, d);
      else if (m_ctrl[8:5] == 4'hF) m_acc = m_acc + d;
    end
  endtask

  task automatic obs(input logic [3:0] ch, input logic s, input logic [31:0] d);
    obs_valid_i = 1'b1; obs_chan_i = ch; obs_sniff_i = s; obs_data_i = d;
    model_obs(ch, s, d);
    @(negedge clk_i);
    obs_valid_i = 1'b0; obs_sniff_i = 1'b0;
  endtask

  task automatic both(input logic [31:0] seed, input logic [31:0] d);
    obs_valid_i = 1'b1; obs_chan_i = m_ctrl[4:1]; obs_sniff_i = 1'b1; obs_data_i = d;
    reg_we_i = 1'b1; reg_addr_i = {2'b00, O_ACC}; reg_wdata_i = seed;
    m_acc = seed;
    @(negedge clk_i);
    obs_valid_i = 1'b0; obs_sniff_i = 1'b0; reg_we_i = 1'b0;
  endtask

  task automatic chk(input logic [13:0] a, input logic [31:0] e, input string tag);
    reg_addr_i = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk_i);
  endtask

  // monitor
  always @(posedge clk_i) begin
    if (exp_q.size() != 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      vectors++;
      if (reg_rdata_o !== e) begin
        fails++;
        $display("FAIL %s: got %08h expected %08h", t, reg_rdata_o, e);
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({2'b00, O_CTRL}, 32'h0, "R1 ctrl");
    chk({2'b00, O_ACC},  32'h0, "R1 acc");

    // CRC on channel 3
    wr(2'b00, O_CTRL, 32'h007);
    chk({2'b00, O_CTRL}, 32'h007, "R7 ctrl plain");
    wr(2'b00, O_ACC, 32'hFFFF_FFFF);
    chk({2'b00, O_ACC}, 32'hFFFF_FFFF, "R4 seed");
    obs(4'd3, 1'b1, 32'h3132_3334);
    chk({2'b00, O_ACC}, view(), "R3 one word");
    obs(4'd3, 1'b1, 32'h3536_3738);
    obs(4'd3, 1'b1, 32'hDEAD_BEEF);
    obs(4'd3, 1'b1, 32'h0000_0000);
    chk({2'b00, O_ACC}, view(), "R3 four words");

    // filtering
    obs(4'd5, 1'b1, 32'h1234_5678);
    obs(4'd3, 1'b0, 32'h1234_5678);
    chk({2'b00, O_ACC}, view(), "R2 wrong chan / no sniff");
    wr(2'b11, O_CTRL, 32'h001);
    obs(4'd3, 1'b1, 32'h1234_5678);
    chk({2'b00, O_ACC}, view(), "R2 disabled");
    wr(2'b10, O_CTRL, 32'h001);

    // add mode
    wr(2'b10, O_CTRL, 32'h1E0);
    chk({2'b00, O_CTRL}, 32'h1E7, "R7 ctrl set alias");
    wr(2'b00, O_ACC, 32'hFFFF_FFF0);
    obs(4'd3, 1'b1, 32'h0000_0020);
    chk({2'b00, O_ACC}, 32'h0000_0010, "R5 wrap");
    obs(4'd3, 1'b1, 32'h1234_5678);
    chk({2'b00, O_ACC}, view(), "R5 sum");

    // unknown calc code 0x3
    wr(2'b11, O_CTRL, 32'h1E0);
    wr(2'b10, O_CTRL, 32'h060);
    chk({2'b00, O_CTRL}, 32'h067, "R7 ctrl clear alias");
    obs(4'd3, 1'b1, 32'hCAFE_F00D);
    chk({2'b00, O_ACC}, view(), "R9 unknown calc");

    // accumulator aliases
    wr(2'b00, O_ACC, 32'hF0F0_1234);
    wr(2'b10, O_ACC, 32'h0F00_0001);
    chk({2'b00, O_ACC}, 32'hFFF0_1235, "R6 set");
    wr(2'b11, O_ACC, 32'h0000_1235);
    chk({2'b00, O_ACC}, 32'hFFF0_0000, "R6 clear");
    wr(2'b01, O_ACC, 32'hFFFF_FFFF);
    chk({2'b00, O_ACC}, 32'h000F_FFFF, "R6 not");

    // readout transforms
    wr(2'b10, O_CTRL, 32'h800);
    chk({2'b00, O_ACC}, 32'hFFF0_0000, "R8 invert");
    wr(2'b01, O_CTRL, 32'hC00);
    chk({2'b00, O_ACC}, 32'hFFFF_F000, "R8 reverse");
    wr(2'b10, O_CTRL, 32'h800);
    chk({2'b00, O_ACC}, 32'h0000_0FFF, "R8 both");
    wr(2'b11, O_CTRL, 32'hC00);
    chk({2'b00, O_ACC}, 32'h000F_FFFF, "R8 raw kept");

    // collision
    wr(2'b00, O_CTRL, 32'h007);
    both(32'hABCD_0000, 32'h5555_AAAA);
    chk({2'b00, O_ACC}, 32'hABCD_0000, "R10 write wins");
    obs(4'd3, 1'b1, 32'h5555_AAAA);
    chk({2'b00, O_ACC}, view(), "R3 after seed");

    // read decode
    chk({2'b11, O_ACC}, view(), "R11 code bits ignored");
    chk({2'b00, 12'h010}, 32'h0, "R11 unmapped");

    @(negedge clk_i);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule